// File: doc/BRIEF.md
# Synthesizer Serial Programming Register Bank

This block is the control port of a dual-channel frequency synthesizer. A controller writes it over three wires: serial data, serial clock and latch enable. Each write is a 21-bit frame. While latch enable is low, the frame is shifted into a staging register, most significant bit first. When latch enable then rises, the frame is committed into one of four held registers.

The last two bits shifted in select the target register. The other nineteen bits are the payload. There are two counter registers, one for each channel. There is also a mode register, which drives the per-channel power-down, charge-pump tri-state and phase-detector polarity controls. The fourth register is a test word, which must be written as zero for normal operation.

All three serial pins are sampled by the system clock. Each pin passes through a synchronizer, and its edges are detected in the system clock domain. The serial port keeps working whatever the power-down state of the channels.

Top module: `synth_prog_bank`

## Requirements
- R1: A frame is 21 bits shifted most significant bit first. The first 19 bits shifted are the payload, bit 18 first. The last two bits shifted form the address, with the final bit as the address LSB.
- R2: The address codes are: 2'b11 selects the channel 1 counter word, 2'b10 the channel 2 counter word, 2'b01 the mode word and 2'b00 the test word. Exactly one held register updates per latch event.
- R3: The staging register shifts on a rising edge of the serial clock only while latch enable is low. Serial clock edges while latch enable is high change neither the staging register nor any held register.
- R4: Held registers change only on a rising edge of latch enable. The new value is visible at the outputs by the third system-clock rising edge after the pin rises.
- R5: After reset, all counter and test outputs are zero and the mode word is zero except its power-down bits. Both channels are therefore powered down, with charge pump not high-Z and polarity inverted.
- R6: The mode payload fields are as follows. Bit 0 powers down channel 1 and bit 1 powers down channel 2 (1 = off). Bits 2 and 3 set the charge pump of channels 1 and 2 to high-Z (1 = high-Z). Bits 4 and 5 set the polarity of channels 1 and 2 (1 = normal, 0 = inverted). Payload bits 18..6 have no effect on any output.
- R7: A channel's charge-pump output enable is high only when the channel is powered on and its high-Z bit is clear. A channel's lock/test output enable is high only when the channel is powered on. Frames are accepted while both channels are powered down.
- R8: When more than 21 bits are shifted before a latch, only the last 21 count.
- R9: Back-to-back frames, with shifting restarting as soon as latch enable falls, each land in their own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_data | input | 1 | Serial data pin |
| ser_le | input | 1 | Latch enable pin |
| cnt1_word | output | 19 | Held channel 1 counter word |
| cnt2_word | output | 19 | Held channel 2 counter word |
| test_word | output | 19 | Held test word |
| pwr_dn | output | 2 | Per-channel power-down (bit 0 = channel 1) |
| cp_hiz | output | 2 | Per-channel charge-pump high-Z request |
| pd_normal | output | 2 | Per-channel phase-detector polarity, 1 = normal |
| cp_oe | output | 2 | Per-channel charge-pump output enable |
| lock_oe | output | 2 | Per-channel lock/test output enable |

## Verification
Shifting and latching can fall in the same system-clock cycle. This happens when the serial clock and latch enable rise together, so that both edges are detected on the same synchronized sample. The bench provokes this by raising both pins at the same instant, with a 1 on the data pin. It expects the latch to commit the previously staged frame with no extra bit shifted in. It then re-latches with no clocking in between and expects identical outputs, which shows that the staging register was left untouched.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int FRAME_W = 21;
  localparam int ADDR_W  = 2;
  localparam int PAY_W   = FRAME_W - ADDR_W;
  localparam int NREG    = 1 << ADDR_W;
  localparam int NCH     = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TEST = 2'b00,
    SEL_MODE = 2'b01,
    SEL_CNT2 = 2'b10,
    SEL_CNT1 = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic [NCH-1:0] pol_norm;
    logic [NCH-1:0] cp_hiz;
    logic [NCH-1:0] pwr_dn;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
  localparam logic [PAY_W-1:0] MODE_RST = {{(PAY_W-NCH){1'b0}}, {NCH{1'b1}}};

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic logic [PAY_W-1:0] frame_payload(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic mode_t mode_fields(input logic [MODE_W-1:0] low_bits);
    return mode_t'(low_bits);
  endfunction

  function automatic logic [NCH-1:0] cp_enable(input mode_t m);
    return ~m.pwr_dn & ~m.cp_hiz;
  endfunction

  function automatic logic [NCH-1:0] lock_enable(input mode_t m);
    return ~m.pwr_dn;
  endfunction
endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] level
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= pin;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import synth_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import synth_prog_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [PAY_W-1:0]           wr_data,
  output logic [NREG-1:0]            wr_sel,
  output logic [NREG-1:0][PAY_W-1:0] regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [PAY_W-1:0] RST_VAL = (g == int'(SEL_MODE)) ? MODE_RST : '0;
    assign wr_sel[g] = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs[g] <= RST_VAL;
      else if (wr_sel[g]) regs[g] <= wr_data;
    end
  end
endmodule

// File: rtl/synth_prog_bank.sv
module synth_prog_bank
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  output logic [PAY_W-1:0] cnt1_word,
  output logic [PAY_W-1:0] cnt2_word,
  output logic [PAY_W-1:0] test_word,
  output logic [NCH-1:0]   pwr_dn,
  output logic [NCH-1:0]   cp_hiz,
  output logic [NCH-1:0]   pd_normal,
  output logic [NCH-1:0]   cp_oe,
  output logic [NCH-1:0]   lock_oe
);
  logic [2:0] pin_lvl;
  logic       sclk_lvl, data_lvl, le_lvl;
  logic       sclk_d, le_d;
  logic       shift_evt, latch_evt;

  logic [FRAME_W-1:0]            frame;
  logic [NREG-1:0]               wr_sel;
  logic [NREG-1:0][PAY_W-1:0]    regs;
  logic [PAY_W-1:0]              mode_word;
  mode_t                         mode;

  sync_pipe #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({ser_le, ser_data, ser_clk}),
    .level(pin_lvl)
  );
  assign {le_lvl, data_lvl, sclk_lvl} = pin_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_lvl;
      le_d   <= le_lvl;
    end
  end

  // Named internal events, observed by the bound checker.
  assign shift_evt = sclk_lvl && !sclk_d && !le_lvl;
  assign latch_evt = le_lvl && !le_d;

  frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_evt), .bit_in(data_lvl),
    .frame(frame)
  );

  reg_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(latch_evt),
    .wr_addr(frame_addr(frame)),
    .wr_data(frame_payload(frame)),
    .wr_sel(wr_sel),
    .regs(regs)
  );

  assign cnt1_word = regs[SEL_CNT1];
  assign cnt2_word = regs[SEL_CNT2];
  assign test_word = regs[SEL_TEST];
  assign mode_word = regs[SEL_MODE];
  assign mode      = mode_fields(mode_word[MODE_W-1:0]);

  assign pwr_dn    = mode.pwr_dn;
  assign cp_hiz    = mode.cp_hiz;
  assign pd_normal = mode.pol_norm;
  assign cp_oe     = cp_enable(mode);
  assign lock_oe   = lock_enable(mode);
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             le_lvl,
  input logic             shift_evt,
  input logic             latch_evt,
  input logic [NREG-1:0]  wr_sel,
  input logic [PAY_W-1:0] cnt1_word,
  input logic [PAY_W-1:0] cnt2_word,
  input logic [PAY_W-1:0] test_word,
  input logic [PAY_W-1:0] mode_word,
  input logic [NCH-1:0]   pwr_dn,
  input logic [NCH-1:0]   cp_hiz,
  input logic [NCH-1:0]   cp_oe,
  input logic [NCH-1:0]   lock_oe
);
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |-> $countones(wr_sel) == 1);

  assert_no_stray_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |-> wr_sel == '0);

  assert_shift_le_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> !le_lvl);

  assert_hold_between_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(cnt1_word) && $stable(cnt2_word) &&
                   $stable(test_word) && $stable(mode_word));

  assert_cp1_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn[0] || cp_hiz[0]) |-> !cp_oe[0]);

  assert_cp2_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn[1] || cp_hiz[1]) |-> !cp_oe[1]);

  assert_lock_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_oe & pwr_dn) == '0);
endmodule

bind synth_prog_bank synth_prog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .le_lvl(le_lvl),
  .shift_evt(shift_evt), .latch_evt(latch_evt), .wr_sel(wr_sel),
  .cnt1_word(cnt1_word), .cnt2_word(cnt2_word), .test_word(test_word),
  .mode_word(mode_word), .pwr_dn(pwr_dn), .cp_hiz(cp_hiz),
  .cp_oe(cp_oe), .lock_oe(lock_oe)
);

// File: tb/synth_prog_bank_tb_top.sv
module synth_prog_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [18:0] cnt1_word, cnt2_word, test_word;
  logic [1:0]  pwr_dn, cp_hiz, pd_normal, cp_oe, lock_oe;

  always #10 clk = ~clk;

  synth_prog_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .cnt1_word(cnt1_word), .cnt2_word(cnt2_word),
    .test_word(test_word), .pwr_dn(pwr_dn), .cp_hiz(cp_hiz),
    .pd_normal(pd_normal), .cp_oe(cp_oe), .lock_oe(lock_oe)
  );

  typedef struct {
    logic [18:0] c1, c2, md, tw;
    string       tag;
  } snap_t;

  snap_t       exp_q[$];
  logic [18:0] m_c1 = '0, m_c2 = '0, m_md = 19'h3, m_tw = '0;
  logic [20:0] staged = '0;
  int          vectors = 0, miscompares = 0;
  bit          finished = 0;

  task automatic cmp(input string tag, input string what, input logic [18:0] act, input logic [18:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input snap_t s);
    logic [1:0] pd, hz, pl;
    pd = s.md[1:0]; hz = s.md[3:2]; pl = s.md[5:4];
    cmp(s.tag, "cnt1_word", cnt1_word, s.c1);
    cmp(s.tag, "cnt2_word", cnt2_word, s.c2);
    cmp(s.tag, "test_word", test_word, s.tw);
    cmp({s.tag, " R6"}, "pwr_dn", {17'd0, pwr_dn}, {17'd0, pd});
    cmp({s.tag, " R6"}, "cp_hiz", {17'd0, cp_hiz}, {17'd0, hz});
    cmp({s.tag, " R6"}, "pd_normal", {17'd0, pd_normal}, {17'd0, pl});
    cmp({s.tag, " R7"}, "cp_oe", {17'd0, cp_oe}, {17'd0, ~pd & ~hz});
    cmp({s.tag, " R7"}, "lock_oe", {17'd0, lock_oe}, {17'd0, ~pd});
  endtask

  // Monitor: pops each expected snapshot once the latch has had time to land.
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      repeat (6) @(posedge clk);
      @(negedge clk);
      check_all(exp_q[0]);
      void'(exp_q.pop_front());
    end
  end

  task automatic shift_bit(input logic b);
    ser_data = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    staged = {staged[19:0], b};
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic push(input string tag);
    snap_t s;
    s.c1 = m_c1; s.c2 = m_c2; s.md = m_md; s.tw = m_tw; s.tag = tag;
    exp_q.push_back(s);
  endtask

  task automatic apply_model();
    case (staged[1:0])
      2'b11: m_c1 = staged[20:2];
      2'b10: m_c2 = staged[20:2];
      2'b01: m_md = staged[20:2];
      default: m_tw = staged[20:2];
    endcase
  endtask

  task automatic latch(input string tag);
    repeat (2) @(negedge clk);
    ser_le = 1'b1;
    apply_model();
    push(tag);
    repeat (8) @(negedge clk);
    ser_le = 1'b0;
  endtask

  task automatic send(input logic [1:0] a, input logic [18:0] p, input string tag);
    logic [20:0] f;
    f = {p, a};
    for (int i = 20; i >= 0; i--) shift_bit(f[i]);
    latch(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    begin
      snap_t r; r.c1 = '0; r.c2 = '0; r.md = 19'h3; r.tw = '0; r.tag = "R5 reset";
      check_all(r);
    end

    send(2'b11, 19'h5A3C1, "R1 R2 cnt1");
    send(2'b10, 19'h2B7E4, "R2 cnt2");
    send(2'b00, 19'h00000, "R2 test zero");
    send(2'b00, 19'h40001, "R2 test nonzero");
    send(2'b01, 19'h7FF00 | 19'h18, "R6 mode high bits ignored");
    send(2'b01, 19'h00026, "R6 mode mix");
    // R7: both channels down, port still accepts frames
    send(2'b01, 19'h00003, "R7 both down");
    send(2'b11, 19'h13579, "R7 write while down");
    send(2'b00, 19'h00000, "R7 test clear while down");

    // R8: four extra leading ones, then a full frame
    for (int i = 0; i < 4; i++) shift_bit(1'b1);
    begin
      logic [20:0] f; f = {19'h0ACE5, 2'b10};
      for (int i = 20; i >= 0; i--) shift_bit(f[i]);
    end
    latch("R8 extra leading bits");

    // R9: back-to-back frames, no idle between latch and next shift
    send(2'b11, 19'h7FFFF, "R9 b2b first");
    send(2'b10, 19'h00001, "R9 b2b second");
    send(2'b01, 19'h00010, "R9 b2b third");

    // R3: clocking while LE high leaves the staged frame intact
    send(2'b11, 19'h31415, "R3 before");
    m_c1 = 19'h0; // scribble then restore through re-latch
    repeat (2) @(negedge clk);
    ser_le = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_data = 1'b1;
      repeat (2) @(negedge clk); ser_clk = 1'b1;
      repeat (2) @(negedge clk); ser_clk = 1'b0;
    end
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
    latch("R3 re-latch after LE-high clocking");

    // R3 R4: serial clock and LE rise together; no bit shifted in
    send(2'b10, 19'h22222, "R4 before coincident");
    ser_data = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    ser_le  = 1'b1;
    apply_model();
    push("R3 coincident edges");
    repeat (8) @(negedge clk);
    ser_clk = 1'b0;
    ser_le  = 1'b0;
    repeat (4) @(negedge clk);
    latch("R3 re-latch after coincident");

    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule